// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block gives a host on a simple byte-wide I/O bus access to a bank of configuration registers through two adjacent I/O addresses. After reset the block is locked, and the configuration registers cannot be read or written. A magic byte written twice in a row to the base address opens the block. The base address then acts as an index latch and the next address acts as a data window onto the indexed register. Writing a single exit byte to the base address locks the block again.

A strap input chooses one of two base addresses. Register index 0x07 holds a device-select number. Indexes from 0x30 upward are stored separately for each logical device, and that number picks the copy in use. The remaining valid indexes are chip-wide and are shared by all devices. A read of the data port returns the selected value in the same cycle as the strobe. A locked or misdirected read returns all ones.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the block is locked. While locked, writes to the data port leave every stored register unchanged.
- R2: When `strap_alt`=0 the base address is 0x2E and the data port is 0x2F. When `strap_alt`=1 they are 0x4E and 0x4F. Accesses to the address pair that is not selected have no effect.
- R3: Two successive writes of 0x87 to the base address unlock the block.
- R4: Once one 0x87 has been written, the block stays locked if the next write is either a base write of any other byte or any data-port write. In that case the next 0x87 counts as the first key byte again.
- R5: While unlocked, a base write of 0xAA locks the block. A new two-write 0x87 sequence can then unlock it again.
- R6: While unlocked, a base write of any byte other than 0xAA loads that byte as the index.
- R7: The `rdata` output is combinational. During a read strobe at the data port while unlocked, it shows the indexed register in the same cycle. In every other case, including a locked state or any other address, it shows 0xFF.
- R8: Indexes 0x02 and 0x07–0x2F are global. The same storage is seen whatever device number is selected.
- R9: Indexes 0x30–0xFE are stored separately for each of 8 devices. The device is chosen by bits [2:0] of register 0x07.
- R10: Indexes 0x00, 0x01, 0x03–0x06 and 0xFF read as 0x00, and writes to them are ignored.
- R11: Locking with 0xAA keeps all register contents and the device number, but resets the index to 0x00.
- R12: Register 0x07 resets to 0x00 and reads back all 8 bits written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E/0x2F, 1 gives 0x4E/0x4F |
| addr | input | 16 | I/O address |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |

## Verification
The bench targets the unlock sequencer's abort paths: a stray base byte or a data write placed between the two key bytes. A sequencer that did not abort on these would open early, and the data port would then return register contents where 0xFF is expected. The bench also sets up data in one device bank, switches the device number, and reads the same index and a global index. A design with a bad bank address would return the wrong device's byte or lose the shared value. Further cases cover exit-and-reenter with a data write issued while locked, reads at the non-selected strap address, and writes to indexes outside the valid set. A design that got these wrong would keep a stale index, accept locked writes, or return non-zero for unused indexes.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;
  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_t;

  localparam logic [7:0] KEY_ENTER   = 8'h87;
  localparam logic [7:0] KEY_EXIT    = 8'hAA;
  localparam logic [7:0] IDX_DEVSEL  = 8'h07;
  localparam logic [7:0] IDX_SPARE   = 8'h02;
  localparam logic [7:0] GLOBAL_LAST = 8'h2F;
  localparam logic [7:0] DEV_FIRST   = 8'h30;
  localparam logic [7:0] IDX_LAST    = 8'hFE;
  localparam logic [7:0] READ_IDLE   = 8'hFF;

  function automatic logic idx_is_global(input logic [7:0] i);
    return (i == IDX_SPARE) || ((i >= IDX_DEVSEL) && (i <= GLOBAL_LAST));
  endfunction

  function automatic logic idx_is_device(input logic [7:0] i);
    return (i >= DEV_FIRST) && (i <= IDX_LAST);
  endfunction
endpackage

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
  import keyed_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       base_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic       exit_o,
  output logic       idx_load_o
);
  lock_state_t state_q, state_d;

  wire enter_key = base_wr && (wdata == KEY_ENTER);
  wire exit_key  = base_wr && (wdata == KEY_EXIT);

  always_comb begin
    state_d = state_q;
    case (state_q)
      LK_LOCKED: if (enter_key) state_d = LK_HALF;
      LK_HALF: begin
        if (enter_key)              state_d = LK_OPEN;
        else if (base_wr || data_wr) state_d = LK_LOCKED;
      end
      LK_OPEN:   if (exit_key) state_d = LK_LOCKED;
      default:   state_d = LK_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_LOCKED;
    else     state_q <= state_d;
  end

  assign open_o     = (state_q == LK_OPEN);
  assign exit_o     = open_o && exit_key;
  assign idx_load_o = open_o && base_wr && !exit_key;

  assert_open_needs_key_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(enter_key));
  assert_abort_relock_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == LK_HALF && (data_wr || (base_wr && !enter_key))) |=> (state_q == LK_LOCKED));
  assert_exit_locks_R5: assert property (@(posedge clk) disable iff (rst)
    (open_o && exit_key) |=> !open_o);
endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic [IDX_W-1:0] din,
  output logic [IDX_W-1:0] idx_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) idx_q <= '0;
    else if (load)    idx_q <= din;
  end

  assert_index_loads_R6: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> (idx_q == $past(din)));
  assert_index_clears_R11: assert property (@(posedge clk) disable iff (rst)
    clear |=> (idx_q == '0));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import keyed_cfg_pkg::*;
#(
  parameter int NUM_DEV = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] idx,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] rd_val
);
  localparam int DEV_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int GLB_DEPTH = int'(GLOBAL_LAST) + 1;
  localparam int GLB_AW    = $clog2(GLB_DEPTH);
  localparam int DEV_DEPTH = (1 << DEV_W) * 256;

  logic [7:0] glb_mem [GLB_DEPTH];
  logic [7:0] dev_mem [DEV_DEPTH];
  logic [7:0] devsel_q;

  wire              is_devsel = (idx == IDX_DEVSEL);
  wire              is_glb    = idx_is_global(idx) && !is_devsel;
  wire              is_dev    = idx_is_device(idx);
  wire [GLB_AW-1:0] glb_addr  = idx[GLB_AW-1:0];
  wire [DEV_W+7:0]  dev_addr  = {devsel_q[DEV_W-1:0], idx};

  always_ff @(posedge clk) begin
    if (rst)                  devsel_q <= 8'h00;
    else if (we && is_devsel) devsel_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (we && is_glb) glb_mem[glb_addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (we && is_dev) dev_mem[dev_addr] <= wdata;
  end

  always_comb begin
    if (is_devsel)   rd_val = devsel_q;
    else if (is_glb) rd_val = glb_mem[glb_addr];
    else if (is_dev) rd_val = dev_mem[dev_addr];
    else             rd_val = 8'h00;
  end

  assert_devsel_write_R12: assert property (@(posedge clk) disable iff (rst)
    (we && is_devsel) |=> (devsel_q == $past(wdata)));
  assert_devsel_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !(we && is_devsel) |=> $stable(devsel_q));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          NUM_DEV  = 8,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  wire [ADDR_W-1:0] base_addr = strap_alt ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_PRI);
  wire [ADDR_W-1:0] data_addr = base_addr + ADDR_W'(1);
  wire base_hit = (addr == base_addr);
  wire data_hit = (addr == data_addr);

  logic       open_w, exit_w, idx_load_w;
  logic [7:0] idx_w, bank_rd;

  cfg_unlock_seq u_seq (
    .clk(clk), .rst(rst),
    .base_wr(wr_en && base_hit), .data_wr(wr_en && data_hit),
    .wdata(wdata), .open_o(open_w), .exit_o(exit_w), .idx_load_o(idx_load_w)
  );

  cfg_index_reg #(.IDX_W(8)) u_idx (
    .clk(clk), .rst(rst), .load(idx_load_w), .clear(exit_w),
    .din(wdata), .idx_q(idx_w)
  );

  cfg_reg_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk(clk), .rst(rst), .idx(idx_w),
    .we(open_w && wr_en && data_hit), .wdata(wdata), .rd_val(bank_rd)
  );

  assign rdata = (open_w && rd_en && data_hit) ? bank_rd : READ_IDLE;

  assert_locked_read_R7: assert property (@(posedge clk) disable iff (rst)
    !open_w |-> (rdata == READ_IDLE));
  assert_bad_index_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (open_w && rd_en && data_hit && !idx_is_global(idx_w) && !idx_is_device(idx_w)) |-> (rdata == 8'h00));
endmodule

// File: tb/keyed_cfg_port_test.sv
module keyed_cfg_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_alt = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = 8'h0;
  logic [7:0]  rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyed_cfg_port uut (
    .clk(clk), .rst(rst), .strap_alt(strap_alt), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  // Behavioural reference: 0 locked, 1 one key seen, 2 open
  int        m_state = 0;
  int        m_idx = 0;
  int        m_dev = 0;
  logic [7:0] m_mem [int];

  function automatic int m_base();
    return strap_alt ? 'h4E : 'h2E;
  endfunction

  function automatic int m_key(int i);
    if (i == 7) return -1;
    if (i == 2 || (i >= 8 && i <= 'h2F)) return i;
    if (i >= 'h30 && i <= 'hFE) return 256 * (1 + (m_dev % 8)) + i;
    return -2;
  endfunction

  function automatic logic [7:0] m_read();
    int k;
    if (!(rd_en && m_state == 2 && addr == m_base() + 1)) return 8'hFF;
    k = m_key(m_idx);
    if (k == -1) return m_dev[7:0];
    if (k == -2) return 8'h00;
    return m_mem.exists(k) ? m_mem[k] : 8'hxx;
  endfunction

  task automatic m_update();
    int k;
    if (rst) begin m_state = 0; m_idx = 0; m_dev = 0; return; end
    if (!wr_en) return;
    if (addr == m_base()) begin
      if (m_state == 0) begin if (wdata == 8'h87) m_state = 1; end
      else if (m_state == 1) m_state = (wdata == 8'h87) ? 2 : 0;
      else if (wdata == 8'hAA) begin m_state = 0; m_idx = 0; end
      else m_idx = wdata;
    end else if (addr == m_base() + 1) begin
      if (m_state == 1) m_state = 0;
      else if (m_state == 2) begin
        k = m_key(m_idx);
        if (k == -1) m_dev = wdata;
        else if (k >= 0) m_mem[k] = wdata;
      end
    end
  endtask

  task automatic cyc(input logic [15:0] a, input logic w, input logic r,
                     input logic [7:0] d, input string req);
    logic [7:0] exp;
    addr = a; wr_en = w; rd_en = r; wdata = d;
    @(negedge clk);
    exp = m_read();
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h rdata=%h expected=%h", req, a, rdata, exp);
    end
    @(posedge clk);
    m_update();
    #1;
  endtask

  task automatic wr_base(input logic [7:0] d, input string req);
    cyc(16'(m_base()), 1'b1, 1'b0, d, req);
  endtask
  task automatic wr_data(input logic [7:0] d, input string req);
    cyc(16'(m_base() + 1), 1'b1, 1'b0, d, req);
  endtask
  task automatic rd_data(input string req);
    cyc(16'(m_base() + 1), 1'b0, 1'b1, 8'h00, req);
  endtask
  task automatic set_reg(input logic [7:0] i, input logic [7:0] d, input string req);
    wr_base(i, req); wr_data(d, req);
  endtask
  task automatic get_reg(input logic [7:0] i, input string req);
    wr_base(i, req); rd_data(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state: locked reads and ignored writes
    rd_data("R1");
    rd_data("R7");
    wr_data(8'h55, "R1");
    // R3 unlock, R12 device select resets to zero, R10 index 0 reads zero
    wr_base(8'h87, "R3"); rd_data("R3");
    wr_base(8'h87, "R3"); rd_data("R10");
    get_reg(8'h07, "R12");
    set_reg(8'h02, 8'h5A, "R8");
    set_reg(8'h20, 8'hC3, "R8");
    set_reg(8'h07, 8'hF9, "R12");           // device 1, upper bits kept
    get_reg(8'h07, "R12");
    set_reg(8'h30, 8'h11, "R9");
    set_reg(8'hFE, 8'h22, "R9");
    set_reg(8'h07, 8'h02, "R9");
    set_reg(8'h30, 8'h33, "R9");
    get_reg(8'h30, "R9");
    get_reg(8'h20, "R8");
    set_reg(8'h07, 8'h01, "R9");
    get_reg(8'h30, "R9");
    get_reg(8'hFE, "R9");
    get_reg(8'h02, "R8");
    set_reg(8'h05, 8'h77, "R10"); rd_data("R10");
    set_reg(8'hFF, 8'h66, "R10"); rd_data("R10");
    set_reg(8'h00, 8'h44, "R10"); rd_data("R10");
    get_reg(8'h02, "R10");
    // R6 index load, read of the index port and of other addresses
    wr_base(8'h2A, "R6");
    cyc(16'(m_base()), 1'b0, 1'b1, 8'h00, "R7");
    cyc(16'h0080, 1'b0, 1'b1, 8'h00, "R7");
    // R5 exit, R1 locked write ignored, R11 index cleared and data kept
    wr_base(8'h02, "R6");
    wr_base(8'hAA, "R5"); rd_data("R5");
    wr_data(8'h99, "R1");
    wr_base(8'h87, "R5"); wr_base(8'h87, "R5");
    rd_data("R11");
    get_reg(8'h07, "R11");
    get_reg(8'h02, "R1");
    get_reg(8'hFE, "R11");
    // R4 abort paths
    wr_base(8'hAA, "R5");
    wr_base(8'h87, "R4"); wr_base(8'h10, "R4"); wr_base(8'h87, "R4"); rd_data("R4");
    wr_data(8'h00, "R4"); wr_base(8'h87, "R4"); rd_data("R4");
    wr_base(8'h87, "R4"); rd_data("R4");
    wr_base(8'h07, "R4"); rd_data("R4");
    wr_base(8'hAA, "R5");
    // R2 strap selects the alternate pair
    strap_alt = 1'b1;
    cyc(16'h002E, 1'b1, 1'b0, 8'h87, "R2");
    cyc(16'h002E, 1'b1, 1'b0, 8'h87, "R2");
    cyc(16'h002F, 1'b0, 1'b1, 8'h00, "R2");
    rd_data("R2");
    wr_base(8'h87, "R2"); wr_base(8'h87, "R2");
    get_reg(8'h07, "R2");
    cyc(16'h002F, 1'b0, 1'b1, 8'h00, "R2");
    cyc(16'h002E, 1'b1, 1'b0, 8'h30, "R2");
    get_reg(8'h30, "R2");
    repeat (3) cyc(16'h0000, 1'b0, 1'b0, 8'h00, "R7");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule